// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a memory-mapped watchdog timer. Software drives it over a simple register bus with an address, a write strobe, write data and combinational read data. Software sets an enable bit, picks a timeout as a power of two, and then has to keep writing a fixed key byte to a restart location. Each key write reloads a down-counter. If software stops doing so, the counter reaches zero and the block drives a system reset pulse of fixed length. After the pulse the counter reloads and keeps guarding.

The timeout is chosen through a range register that holds two equal code fields. The low field sets the period, which is 2^(BASE_EXP + code) clock cycles. When the watchdog is disabled, the count freezes. Enabling it again resumes from the frozen value, so software normally follows an enable with a key write to start a fresh period.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the control word (byte offset 0x00) and the range word (offset 0x04) both read 0, and the reset output is low.
- R2: Bit 0 of the control word is the enable and reads back as written. Bit 1, the response-mode select, always reads 0 because only the direct-reset response exists. Writing a control word with bit 0 cleared disables the watchdog.
- R3: The range word stores bits 7:0 of the written value: code field A in bits 3:0 and code field B in bits 7:4. Both fields read back, and bits above 7 read 0.
- R4: While enabled, a restart key write loads the counter with 2^(BASE_EXP + A). The reset output then rises exactly 2^(BASE_EXP + A) + 1 cycles after the key write's clock edge.
- R5: The reset output stays high for exactly PULSE_LEN cycles (8 by default). The counter then reloads, and the next pulse rises 2^(BASE_EXP + A) + 1 cycles after the previous one fell.
- R6: A key write (value 0x76 in bits 7:0 at offset 0x0C) in the middle of a count restarts the full period from that write.
- R7: A write to offset 0x0C whose bits 7:0 are not 0x76 is ignored, and the count continues unchanged.
- R8: While disabled, the counter holds and no reset pulse starts. Re-enabling resumes the count from the held value.
- R9: A key write while the watchdog is disabled has no effect on the count.
- R10: Reads of offset 0x0C, of offset 0x08 and of any other unmapped or misaligned address return 0. Writes to unmapped addresses change no register.
- R11: Code field B has no effect on the period. Only code field A selects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i (combinational) |
| wdt_rst_o | output | 1 | System reset request, high for PULSE_LEN cycles on expiry |

## Verification
The assertions check on every cycle how the counter steps:
- an enabled, unkicked count decrements by one;
- a disabled count holds;
- a key write lands the period;
- a pulse can only start from an enabled zero count, and the counter reloads when it ends.

Only the bench scenarios can show the end-to-end cycle counts from a key write or re-enable to the reset edge, the exact pulse width, register readback, and that a bad key or a key sent while disabled leaves the reset timing unchanged. The bench sweeps the range codes of a small counter and computes each period arithmetically.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int unsigned OFS_CTRL  = 0;
   localparam int unsigned OFS_RANGE = 4;
   localparam int unsigned OFS_KICK  = 12;
   localparam logic [7:0]  KICK_KEY  = 8'h76;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_RANGE,
      SEL_KICK
   } wdt_sel_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CODE_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              en_o,
   output logic [CODE_W-1:0] code_o,
   output logic              kick_o
);
   localparam int unsigned RANGE_W = 2 * CODE_W;

   if (DATA_W <= RANGE_W || DATA_W < 8) begin : g_bad_data_w
      $error("wdt_regs: DATA_W must exceed both code fields and hold the key byte");
   end
   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("wdt_regs: ADDR_W too small for the register offsets");
   end

   wdt_sel_e            sel;
   logic                en_q;
   logic [RANGE_W-1:0]  range_q;
   logic                unused_wdata;

   assign unused_wdata = ^wdata_i[DATA_W-1:RANGE_W];

   always_comb begin
      if (addr_i == ADDR_W'(OFS_CTRL))       sel = SEL_CTRL;
      else if (addr_i == ADDR_W'(OFS_RANGE)) sel = SEL_RANGE;
      else if (addr_i == ADDR_W'(OFS_KICK))  sel = SEL_KICK;
      else                                   sel = SEL_NONE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q    <= 1'b0;
         range_q <= '0;
      end else if (we_i) begin
         if (sel == SEL_CTRL)  en_q    <= wdata_i[0];
         if (sel == SEL_RANGE) range_q <= wdata_i[RANGE_W-1:0];
      end
   end

   always_comb begin
      unique case (sel)
         SEL_CTRL:  rdata_o = DATA_W'(en_q);
         SEL_RANGE: rdata_o = DATA_W'(range_q);
         default:   rdata_o = '0;
      endcase
   end

   assign kick_o = we_i && (sel == SEL_KICK) && (wdata_i[7:0] == KICK_KEY);
   assign en_o   = en_q;
   assign code_o = range_q[CODE_W-1:0];

   AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(OFS_CTRL)) |=> (en_o == $past(wdata_i[0]))); // R2

   AST_UNMAPPED_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && sel == SEL_NONE) |=> ($stable(en_o) && $stable(code_o))); // R10
endmodule

// File: rtl/wdt_period.sv
module wdt_period #(
   parameter int unsigned CODE_W     = 4,
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned BASE_EXP   = 16,
   parameter bit          TABLE_IMPL = 1'b0
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [CNT_W-1:0]  period_o
);
   localparam int unsigned NCODE = 1 << CODE_W;

   if (BASE_EXP + NCODE - 1 >= CNT_W) begin : g_bad_span
      $error("wdt_period: longest period does not fit the counter");
   end

   if (TABLE_IMPL) begin : g_table
      logic [CNT_W-1:0] tbl [NCODE];
      for (genvar g = 0; g < NCODE; g++) begin : g_entry
         assign tbl[g] = CNT_W'(1) << (BASE_EXP + g);
      end
      assign period_o = tbl[code_i];
   end else begin : g_shift
      assign period_o = CNT_W'(1) << (BASE_EXP + int'(code_i));
   end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned BASE_EXP  = 16,
   parameter int unsigned PULSE_LEN = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             kick_i,
   input  logic [CNT_W-1:0] period_i,
   output logic             rst_o
);
   localparam int unsigned PULSE_W = $clog2(PULSE_LEN + 1);
   localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(1) << BASE_EXP;

   if (PULSE_LEN < 1) begin : g_bad_pulse
      $error("wdt_counter: PULSE_LEN must be at least 1");
   end

   logic [CNT_W-1:0]   cnt_q;
   logic [PULSE_W-1:0] pulse_q;
   logic               idle;
   logic               reload;

   assign idle   = (pulse_q == '0);
   assign reload = (kick_i && en_i) || (pulse_q == PULSE_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= RST_CNT;
         pulse_q <= '0;
      end else begin
         if (reload)
            cnt_q <= period_i;
         else if (en_i && idle && cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);

         if (!idle)
            pulse_q <= pulse_q - PULSE_W'(1);
         else if (en_i && !kick_i && cnt_q == '0)
            pulse_q <= PULSE_W'(PULSE_LEN);
      end
   end

   assign rst_o = !idle;

   AST_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !kick_i && idle && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1)))); // R7

   AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && idle) |=> (cnt_q == $past(cnt_q) && !rst_o)); // R8

   AST_KEY_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && kick_i) |=> (cnt_q == $past(period_i))); // R6

   AST_RISE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_o) |-> ($past(cnt_q) == '0 && $past(en_i))); // R4

   AST_FALL_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rst_o) |-> (cnt_q == $past(period_i))); // R5

   AST_PULSE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pulse_q <= PULSE_W'(PULSE_LEN))); // R5
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned CODE_W     = 4,
   parameter int unsigned BASE_EXP   = 16,
   parameter int unsigned PULSE_LEN  = 8,
   parameter bit          TABLE_IMPL = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_we_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              wdt_rst_o
);
   logic              en;
   logic              kick;
   logic [CODE_W-1:0] code;
   logic [CNT_W-1:0]  period;

   wdt_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CODE_W (CODE_W)
   ) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .addr_i  (bus_addr_i),
      .we_i    (bus_we_i),
      .wdata_i (bus_wdata_i),
      .rdata_o (bus_rdata_o),
      .en_o    (en),
      .code_o  (code),
      .kick_o  (kick)
   );

   wdt_period #(
      .CODE_W     (CODE_W),
      .CNT_W      (CNT_W),
      .BASE_EXP   (BASE_EXP),
      .TABLE_IMPL (TABLE_IMPL)
   ) u_period (
      .code_i   (code),
      .period_o (period)
   );

   wdt_counter #(
      .CNT_W     (CNT_W),
      .BASE_EXP  (BASE_EXP),
      .PULSE_LEN (PULSE_LEN)
   ) u_counter (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en),
      .kick_i   (kick),
      .period_i (period),
      .rst_o    (wdt_rst_o)
   );

   AST_NO_RST_WHILE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en && !wdt_rst_o) |=> !wdt_rst_o); // R8
endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
   localparam int BASE = 2;
   localparam int PLEN = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wdt_rst;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   keyed_watchdog #(.CNT_W(20), .BASE_EXP(BASE), .PULSE_LEN(PLEN)) uut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .bus_addr_i  (bus_addr),
      .bus_we_i    (bus_we),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .wdt_rst_o   (wdt_rst)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called at a negedge; returns at the next negedge
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0; bus_addr = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
      bus_addr = '0;
   endtask

   task automatic wait_lvl(input logic lvl, output int n);
      n = 0;
      while (wdt_rst !== lvl && n < 5000) begin
         @(negedge clk);
         n++;
      end
   endtask

   function automatic int per(input int code);
      return 1 << (BASE + code);
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R4: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int n, w, g, low;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(4'h0, v); check("R1 ctrl", int'(v), 0);
      rd(4'h4, v); check("R1 range", int'(v), 0);
      check("R1 rst", int'(wdt_rst), 0);

      // R2 enable readback, mode bit reads 0, disable
      wr(4'h0, 32'h3);
      rd(4'h0, v); check("R2 enable", int'(v), 1);
      wr(4'h0, 32'h0);
      rd(4'h0, v); check("R2 disable", int'(v), 0);

      // R3 range readback
      wr(4'h4, 32'hFFFF_FFA5);
      rd(4'h4, v); check("R3 range", int'(v), 32'hA5);

      // R10 unmapped reads and writes
      rd(4'h8, v); check("R10 read 0x08", int'(v), 0);
      rd(4'hC, v); check("R10 read 0x0C", int'(v), 0);
      rd(4'h2, v); check("R10 read 0x02", int'(v), 0);
      wr(4'h8, 32'hFFFF_FFFF);
      wr(4'h1, 32'hFFFF_FFFF);
      rd(4'h0, v); check("R10 ctrl kept", int'(v), 0);
      rd(4'h4, v); check("R10 range kept", int'(v), 32'hA5);

      // R4/R5 sweep over codes
      wr(4'h0, 32'h1);
      for (int c = 0; c < 10; c++) begin
         wr(4'h4, 32'((c << 4) | c));
         wr(4'hC, 32'h76);
         wait_lvl(1'b1, n); check($sformatf("R4 code %0d rise", c), n, per(c) + 1);
         wait_lvl(1'b0, w); check($sformatf("R5 code %0d width", c), w, PLEN);
         wait_lvl(1'b1, g); check($sformatf("R5 code %0d gap", c), g, per(c) + 1);
         wait_lvl(1'b0, w);
      end

      // R11 upper field ignored: low code 3, upper 9
      wr(4'h4, 32'h93);
      wr(4'hC, 32'h76);
      wait_lvl(1'b1, n); check("R11 low field only", n, per(3) + 1);
      wait_lvl(1'b0, w);

      // R6 mid-count key restarts the period
      wr(4'hC, 32'h76);
      repeat (10) @(negedge clk);
      wr(4'hC, 32'h0000_1176);
      wait_lvl(1'b1, n); check("R6 restart", n, per(3) + 1);
      wait_lvl(1'b0, w);

      // R7 bad keys ignored
      wr(4'hC, 32'h76);
      wr(4'hC, 32'h75);
      wr(4'hC, 32'h67);
      wr(4'hC, 32'h0000_7600);
      wait_lvl(1'b1, n); check("R7 bad key", n + 3, per(3) + 1);
      wait_lvl(1'b0, w);

      // R8 hold while disabled, resume on enable
      wr(4'h4, 32'h22);
      wr(4'hC, 32'h76);
      wr(4'h0, 32'h0);
      low = 1;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (wdt_rst) low = 0;
      end
      check("R8 no pulse while off", low, 1);
      wr(4'h0, 32'h1);
      wait_lvl(1'b1, n); check("R8 resume", n, per(2));
      wait_lvl(1'b0, w);

      // R9 key while disabled has no effect
      wr(4'hC, 32'h76);
      wr(4'h0, 32'h0);
      wr(4'hC, 32'h76);
      repeat (30) @(negedge clk);
      check("R9 still low", int'(wdt_rst), 0);
      wr(4'h0, 32'h1);
      wait_lvl(1'b1, n); check("R9 key ignored", n, per(2));
      wait_lvl(1'b0, w);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule